// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns a floating-point value that has already been unpacked into a signed two's-complement integer. The integer is `W` bits wide and is 32 by default; the wide variant uses 64. The input has five parts: a class code, a sign, an unbiased exponent, a normalised mantissa and a sticky bit. The mantissa's leading one sits at bit `MANT_W-1`, so a number's value is `mant * 2^(exp - (MANT_W-1))`. The conversion always truncates toward zero. No rounding mode is consulted.

Any bit the truncation discards raises an inexact flag. Values outside the integer range raise an invalid flag and saturate. Infinities and NaNs are treated the same way. Saturation is asymmetric by sign: the most negative integer is a legal result, but its positive mirror is not. When a value overflows, the inexact flag is dropped and only invalid is reported.

The result passes through one output register. The register captures on an input strobe, and the output strobe follows one cycle later.

Top module: `ftoi_trunc`

## Requirements
- R1: A class code of 0 (zero) gives an integer of 0 with both flags clear, whatever the sign, mantissa and sticky inputs are.
- R2: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN) are treated as overflow.
- R3: A class code of 1 (number) with an exponent of `W` or more is treated as overflow.
- R4: For a number with exponent e in 0..W-1, the magnitude is the mantissa shifted right by `MANT_W-1-e`. The result is that magnitude, or its two's-complement negation when the sign is 1.
- R5: For a number that does not overflow, inexact is 1 exactly when a nonzero bit is shifted out or the sticky input is 1.
- R6: A number with a negative exponent gives 0. Inexact is then set, because the normalised mantissa is nonzero.
- R7: A number overflows when its magnitude is at least `2^(W-1)` plus the sign bit. So `-2^(W-1)` is returned as a legal result, and `+2^(W-1)` overflows.
- R8: On overflow, invalid is 1 and inexact is 0. The integer is `2^(W-1)-1` when the sign is 0, and `2^(W-1)` as a bit pattern (0x80000000 at 32 bits) when the sign is 1.
- R9: The output registers load when `in_valid` is 1, and `out_valid` is `in_valid` delayed by one cycle. When `in_valid` is 0 the outputs hold their values. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_sign | input | 1 | Sign, 1 means negative |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Normalised mantissa, leading one at bit MANT_W-1 |
| in_sticky | input | 1 | OR of the bits already dropped below the mantissa |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_int | output | W | Signed integer result |
| out_inexact | output | 1 | Truncation discarded nonzero bits |
| out_invalid | output | 1 | Overflow, infinity or NaN |

## Verification
The bench sweeps the exponent from below zero up to `W+2` for both signs. This catches a shift amount that is off by one: such a design would return a doubled or halved magnitude, or would miss overflow at exponent `W`. Both signs are driven at exponent `W-1` with the magnitude equal to `2^(W-1)`. A design with a symmetric limit would either reject `-2^(W-1)` or accept `+2^(W-1)`. Each overflow is checked for a cleared inexact flag, which a design that only ORs the flags would leave set. The bench also drives a zero class with the sticky input set, and a sticky input that is the only lost bit. A design that lets the sticky bit leak into the zero case, or ignores it for numbers, gets the inexact flag wrong.

// File: rtl/ftoi_pkg.sv
package ftoi_pkg;
  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_NUM  = 3'd1,
    FC_INF  = 3'd2,
    FC_QNAN = 3'd3,
    FC_SNAN = 3'd4
  } fclass_e;
endpackage

// File: rtl/ftoi_align.sv
// Moves the integer part of the mantissa into the low W bits and reports discarded bits.
module ftoi_align #(
  parameter int W      = 32,
  parameter int MANT_W = 48,
  parameter int EXP_W  = 12
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  exp_in,
  output logic [W-1:0]      mag,
  output logic              lost,
  output logic              big_exp
);
  localparam int TOP = MANT_W - 1;

  function automatic logic [MANT_W-1:0] low_mask(input int sh);
    logic [MANT_W-1:0] mk;
    for (int i = 0; i < MANT_W; i++) mk[i] = (i < sh);
    return mk;
  endfunction

  function automatic logic [MANT_W-1:0] shift_down(input logic [MANT_W-1:0] m, input int sh);
    return m >> sh;
  endfunction

  int e;
  int sh;
  logic [MANT_W-1:0] wide;

  always_comb begin
    e       = int'($signed(exp_in));
    sh      = 0;
    wide    = '0;
    mag     = '0;
    lost    = 1'b0;
    big_exp = (e >= W);
    if (e < 0) begin
      lost = |mant;
    end else if (e < W) begin
      sh   = TOP - e;
      wide = shift_down(mant, sh);
      mag  = wide[W-1:0];
      lost = |(mant & low_mask(sh));
    end
  end
endmodule

// File: rtl/ftoi_range.sv
// Decides overflow: non-finite class, large exponent, or sign-dependent magnitude limit.
module ftoi_range #(
  parameter int W = 32
) (
  input  ftoi_pkg::fclass_e cls,
  input  logic              sign,
  input  logic              big_exp,
  input  logic [W-1:0]      mag,
  output logic              ovf
);
  import ftoi_pkg::*;

  function automatic logic mag_too_big(input logic [W-1:0] m, input logic s);
    logic [W:0] limit;
    limit = {2'b01, {(W-1){1'b0}}} + {{W{1'b0}}, s};
    return ({1'b0, m} >= limit);
  endfunction

  always_comb begin
    case (cls)
      FC_ZERO: ovf = 1'b0;
      FC_NUM:  ovf = big_exp || mag_too_big(mag, sign);
      default: ovf = 1'b1;
    endcase
  end
endmodule

// File: rtl/ftoi_result.sv
// Forms the signed result and the two flags.
module ftoi_result #(
  parameter int W = 32
) (
  input  ftoi_pkg::fclass_e cls,
  input  logic              sign,
  input  logic              ovf,
  input  logic [W-1:0]      mag,
  input  logic              lost,
  input  logic              sticky,
  output logic [W-1:0]      res,
  output logic              inexact,
  output logic              invalid
);
  import ftoi_pkg::*;

  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  function automatic logic [W-1:0] apply_sign(input logic [W-1:0] m, input logic s);
    return s ? (~m + 1'b1) : m;
  endfunction

  always_comb begin
    res     = '0;
    inexact = 1'b0;
    invalid = 1'b0;
    if (ovf) begin
      res     = MAX_POS + {{(W-1){1'b0}}, sign};
      invalid = 1'b1;
    end else if (cls == FC_NUM) begin
      res     = apply_sign(mag, sign);
      inexact = lost | sticky;
    end
  end
endmodule

// File: rtl/ftoi_trunc.sv
module ftoi_trunc #(
  parameter int W      = 32,
  parameter int MANT_W = 48,
  parameter int EXP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  output logic              out_valid,
  output logic [W-1:0]      out_int,
  output logic              out_inexact,
  output logic              out_invalid
);
  import ftoi_pkg::*;

  fclass_e        w_cls;
  logic [W-1:0]   w_mag;
  logic           w_lost;
  logic           w_big;
  logic           w_ovf;
  logic [W-1:0]   w_res;
  logic           w_nx;
  logic           w_nv;

  assign w_cls = fclass_e'(in_class);

  ftoi_align #(.W(W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .mant(in_mant), .exp_in(in_exp), .mag(w_mag), .lost(w_lost), .big_exp(w_big)
  );

  ftoi_range #(.W(W)) u_range (
    .cls(w_cls), .sign(in_sign), .big_exp(w_big), .mag(w_mag), .ovf(w_ovf)
  );

  ftoi_result #(.W(W)) u_result (
    .cls(w_cls), .sign(in_sign), .ovf(w_ovf), .mag(w_mag), .lost(w_lost),
    .sticky(in_sticky), .res(w_res), .inexact(w_nx), .invalid(w_nv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= w_res;
        out_inexact <= w_nx;
        out_invalid <= w_nv;
      end
    end
  end
endmodule

// File: rtl/ftoi_trunc_chk.sv
module ftoi_trunc_chk #(
  parameter int W     = 32,
  parameter int EXP_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       in_class,
  input logic [EXP_W-1:0] in_exp,
  input logic             w_ovf,
  input logic             out_valid,
  input logic [W-1:0]     out_int,
  input logic             out_inexact,
  input logic             out_invalid
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
  AST_HOLD_INT: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_int)); // R9
  AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 3'd0) |=> (out_int == '0 && !out_inexact && !out_invalid)); // R1
  AST_NONFINITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_class == 3'd2 || in_class == 3'd3 || in_class == 3'd4)) |=> out_invalid); // R2
  AST_BIG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 3'd1 && $signed(in_exp) >= $signed(W)) |=> out_invalid); // R3
  AST_OVF_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && w_ovf) |=> (out_invalid && !out_inexact)); // R8
  AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_int == MAX_POS || out_int == MIN_NEG)); // R8
endmodule

bind ftoi_trunc ftoi_trunc_chk #(.W(W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class), .in_exp(in_exp),
  .w_ovf(w_ovf), .out_valid(out_valid), .out_int(out_int),
  .out_inexact(out_inexact), .out_invalid(out_invalid)
);

// File: tb/tb_ftoi_trunc.sv
`timescale 1ns/1ps
module tb_ftoi_trunc;
  localparam int W = 32;
  localparam int MANT_W = 48;
  localparam int EXP_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] in_class = 3'd0;
  logic in_sign = 1'b0;
  logic [EXP_W-1:0] in_exp = '0;
  logic [MANT_W-1:0] in_mant = '0;
  logic in_sticky = 1'b0;
  logic out_valid;
  logic [W-1:0] out_int;
  logic out_inexact, out_invalid;

  always #2.5 clk = ~clk;

  ftoi_trunc #(.W(W), .MANT_W(MANT_W), .EXP_W(EXP_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky), .out_valid(out_valid),
    .out_int(out_int), .out_inexact(out_inexact), .out_invalid(out_invalid)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit exp_valid = 0;
  logic [31:0] exp_int = '0;
  bit exp_nx = 0, exp_nv = 0;
  string cur_tag = "R9";

  // Reference: value = m * 2^(e-47); truncate toward zero, saturate asymmetrically.
  task automatic model(input int c, input bit s, input int e, input longint unsigned m,
                       input bit st, output logic [31:0] r, output bit nx, output bit nv);
    longint unsigned mag, rem;
    bit ovf;
    r = 0; nx = 0; nv = 0; ovf = 0; mag = 0; rem = 0;
    if (c == 0) return;
    if (c != 1 || e >= 32) ovf = 1;
    else if (e < 0) begin
      mag = 0; rem = m;
    end else begin
      mag = m >> (47 - e);
      rem = m - (mag << (47 - e));
    end
    if (!ovf && mag >= 64'h8000_0000 + longint'(s)) ovf = 1;
    if (ovf) begin
      r = s ? 32'h8000_0000 : 32'h7FFF_FFFF; nv = 1;
    end else begin
      r = s ? (32'd0 - mag[31:0]) : mag[31:0];
      nx = (rem != 0) || st;
    end
  endtask

  task automatic check_bit(input string what, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", cur_tag, what, act, expv);
    end
  endtask

  task automatic compare();
    checks++;
    if (out_valid !== exp_valid) begin
      errors++;
      $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, exp_valid);
    end
    checks++;
    if (out_int !== exp_int) begin
      errors++;
      $display("FAIL %s out_int actual=%h expected=%h", cur_tag, out_int, exp_int);
    end
    check_bit("inexact", out_inexact, exp_nx);
    check_bit("invalid", out_invalid, exp_nv);
  endtask

  task automatic step(input bit v, input int c, input bit s, input int e,
                      input longint unsigned m, input bit st, input string tag);
    logic [31:0] r;
    bit nx, nv;
    @(negedge clk);
    compare();
    in_valid = v; in_class = c[2:0]; in_sign = s; in_exp = e[EXP_W-1:0];
    in_mant = m[MANT_W-1:0]; in_sticky = st;
    exp_valid = v;
    if (v) begin
      model(c, s, e, m, st, r, nx, nv);
      exp_int = r; exp_nx = nx; exp_nv = nv; cur_tag = tag;
    end else begin
      cur_tag = "R9";
    end
  endtask

  localparam longint unsigned ONE = 64'h8000_0000_0000;

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R9";
    compare();  // reset state R9
    rst_n = 1'b1;
    // R1: zero class, garbage on other inputs
    step(1, 0, 0, 5, ONE | 48'h123, 1, "R1");
    step(1, 0, 1, 40, ONE, 1, "R1");
    // R2: non-finite classes
    for (int c = 2; c <= 4; c++) begin
      step(1, c, 0, 3, ONE, 0, "R2");
      step(1, c, 1, 3, ONE, 1, "R2");
    end
    // R9: idle cycles hold output
    step(0, 1, 0, 3, ONE, 0, "R9");
    step(0, 0, 1, 0, 0, 0, "R9");
    // R4/R5: exact small values and ones
    step(1, 1, 0, 0, ONE, 0, "R4");
    step(1, 1, 1, 0, ONE, 0, "R4");
    step(1, 1, 0, 3, ONE | 48'h1000_0000_0000, 0, "R5");
    step(1, 1, 1, 3, ONE | 48'h0000_0000_0001, 0, "R5");
    step(1, 1, 0, 10, ONE, 1, "R5");  // sticky only
    // R6: negative exponents
    step(1, 1, 0, -1, ONE, 0, "R6");
    step(1, 1, 1, -30, ONE, 0, "R6");
    // R7: boundary at 2^(W-1)
    step(1, 1, 1, 31, ONE, 0, "R7");
    step(1, 1, 0, 31, ONE, 0, "R7");
    step(1, 1, 1, 31, ONE | 48'h1, 0, "R7");
    step(1, 1, 1, 31, ONE, 1, "R7");
    step(1, 1, 0, 30, 48'hFFFF_FFFF_FFFF, 0, "R7");
    // R8: overflow with bits that would be inexact
    step(1, 1, 0, 32, 48'hFFFF_FFFF_FFFF, 1, "R8");
    step(1, 1, 1, 33, 48'hFFFF_FFFF_FFFF, 1, "R8");
    // Sweep exponents for both signs (R3/R4/R6)
    for (int e = -4; e <= W + 2; e++) begin
      for (int s = 0; s < 2; s++) begin
        longint unsigned pat;
        pat = ONE | ((64'h5A5A_1234_ABCD ^ (longint'(e) * 64'h0101_0F0F)) & 64'h7FFF_FFFF_FFFF);
        step(1, 1, s[0], e, pat, e[0], (e < 0) ? "R6" : (e >= W) ? "R3" : "R4");
      end
    end
    step(0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R9");
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule